// File: doc/BRIEF.md
# Leading-Edge Pulse Timer

This block measures when the leading edge of a pulse arrives, to a fraction of a sample, from a buffer of ADC samples. After a start request it reads the buffer through a combinational read port. It first looks for the first sample that reaches a trigger level. It then takes a fixed window of samples that begins a few samples before that point. Inside the window it finds a sample at or above a high threshold. From there it walks backwards to the last sample at or below a low threshold, which gives a coarse crossing.

An external upsampling filter then delivers eight interpolated points around the coarse crossing. The block scans those points from the last one back to the first to refine the crossing. It then divides the remaining gap serially to get a fraction of one upsample step. The division uses repeated addition with a fixed bound on the number of steps. A crossing that would give a non-positive divisor is caught before the division starts, so the loop cannot run away. In that case the block reports an error and does not return a fraction.

Top module: `edge_timer`

## Requirements
- R1: After start_i, buffer addresses are read from 0 upward, and the first sample that is at least trig_lvl_i is the trigger. If no sample in the 64-entry buffer reaches the trigger level, the run ends with hit_o=0 and err_o=0, and coarse_o, refine_o and frac_o are all 0.
- R2: The window starts 9 samples before the trigger sample, or at address 0 if the trigger sample is earlier than that. The window is 15 samples long and is cut short at the end of the buffer.
- R3: The high search runs forward through the window for the first sample that is at least hi_thr_i. From that sample, the low search runs backwards, down to the window start, for the first sample that is at most lo_thr_i. coarse_o is (low sample address minus window start) times 10. If either search fails, err_o=1.
- R4: Once the low crossing is found, up_req_o is high for exactly one cycle and up_idx_o gives the absolute buffer address of the crossing. The next eight up_valid_i beats are taken in order as points 0 to 7. Point j stands for position (crossing - 0.2 + 0.2*j) samples.
- R5: The points are scanned from 7 down to 0 for the first one that is at most lo_thr_i (compared as a signed value). refine_o is twice that point's index. If no point qualifies, err_o=1 and refine_o=0.
- R6: If the chosen point is point 7, there is no following point to interpolate towards. The same holds if the following point minus the chosen point is zero or negative. In either case err_o=1 and no division takes place.
- R7: Otherwise frac_o is the smallest c from 0 to 8 for which c*(next - chosen) >= 8*(lo_thr_i - chosen), and it is capped at 8. frac_o counts eighths of one upsample step. Whenever err_o=1, frac_o is 0.
- R8: The division never takes more than 8 addition steps.
- R9: done_o is high for exactly one cycle at the end of each run. The result outputs keep their values until the next accepted start.
- R10: A start_i pulse while a run is in progress is ignored. The run's results are unchanged, and it produces a single done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a measurement (accepted when idle) |
| trig_lvl_i | input | 12 | Trigger level |
| hi_thr_i | input | 12 | High timing threshold |
| lo_thr_i | input | 12 | Low timing threshold |
| rd_addr_o | output | 6 | Sample buffer read address |
| rd_data_i | input | 12 | Sample at rd_addr_o, same cycle |
| up_req_o | output | 1 | One-cycle request for upsampled points |
| up_idx_o | output | 6 | Buffer address of the coarse crossing |
| up_valid_i | input | 1 | Upsampled point valid |
| up_data_i | input | 16 | Upsampled point, signed |
| done_o | output | 1 | One-cycle end-of-run pulse |
| hit_o | output | 1 | Trigger level was reached |
| err_o | output | 1 | Timing could not be completed |
| coarse_o | output | 8 | Coarse crossing time in tenths of a sample |
| refine_o | output | 4 | Refined offset inside the upsampled window, tenths |
| frac_o | output | 4 | Fraction of one upsample step, eighths |

## Verification
Every result is registered before done_o rises, so the bench reads them at the falling edge of the cycle in which done_o is high, and checks at the next falling edge that done_o has dropped. up_req_o and up_idx_o are read at the falling edge of the request cycle. The eight upsampled beats are then driven on the falling edges that follow, so each beat is captured at the rising edge after it is driven. The time each run takes depends on where the crossings lie and on how many division steps are needed. For that reason the bench waits for done_o rather than counting a fixed latency, and a per-run limit flags a run that never finishes.

// File: rtl/edge_timer_pkg.sv
package edge_timer_pkg;
  localparam int TENTHS = 10;

  typedef enum logic [2:0] {
    S_IDLE, S_TRIG, S_HIGH, S_LOW, S_UPW, S_FINE, S_DIV, S_DONE
  } et_state_e;
endpackage

// File: rtl/et_upbuf.sv
module et_upbuf #(
  parameter int NUP = 8,
  parameter int UW  = 16,
  localparam int KW = $clog2(NUP)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    valid_i,
  input  logic [UW-1:0]           data_i,
  output logic                    full_o,
  output logic [NUP-1:0][UW-1:0]  pts_o
);
  logic [KW:0] wr_q;

  assign full_o = (wr_q == (KW+1)'(NUP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wr_q <= '0;
    else if (clr_i)             wr_q <= '0;
    else if (valid_i && !full_o) wr_q <= wr_q + 1'b1;
  end

  for (genvar g = 0; g < NUP; g++) begin : g_ent
    logic [UW-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= '0;
      else if (valid_i && !full_o && wr_q == (KW+1)'(g)) ent_q <= data_i;
    end
    assign pts_o[g] = ent_q;
  end

  AST_UP_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !valid_i); // R4
endmodule

// File: rtl/et_serdiv.sv
module et_serdiv #(
  parameter int SW    = 24,
  parameter int LIMIT = 8,
  localparam int FW   = $clog2(LIMIT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [SW-1:0] num_i,
  input  logic signed [SW-1:0] den_i,
  output logic                 done_o,
  output logic [FW-1:0]        cnt_o
);
  logic                 run_q;
  logic signed [SW-1:0] sum_q, tgt_q, den_q;
  logic [FW-1:0]        cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; done_o <= 1'b0; sum_q <= '0; tgt_q <= '0; den_q <= '0; cnt_q <= '0;
    end else if (start_i) begin
      run_q  <= 1'b1;
      done_o <= 1'b0;
      sum_q  <= '0;
      cnt_q  <= '0;
      tgt_q  <= num_i * $signed(SW'(LIMIT));
      den_q  <= den_i;
    end else if (run_q) begin
      if (sum_q >= tgt_q || cnt_q == FW'(LIMIT)) begin
        run_q  <= 1'b0;
        done_o <= 1'b1;
      end else begin
        sum_q <= sum_q + den_q;
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FW'(LIMIT)); // R8
  AST_DIV_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
endmodule

// File: rtl/edge_timer.sv
module edge_timer
  import edge_timer_pkg::*;
#(
  parameter int N     = 64,
  parameter int DW    = 12,
  parameter int UW    = 16,
  parameter int PRE   = 9,
  parameter int SUB   = 15,
  parameter int NUP   = 8,
  parameter int STEP  = 2,
  parameter int LIMIT = 8,
  localparam int AW   = $clog2(N),
  localparam int KW   = $clog2(NUP),
  localparam int CW   = $clog2((SUB - 1) * TENTHS + 1),
  localparam int RW   = $clog2((NUP - 1) * STEP + 1),
  localparam int FW   = $clog2(LIMIT + 1),
  localparam int SW   = UW + 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] trig_lvl_i,
  input  logic [DW-1:0] hi_thr_i,
  input  logic [DW-1:0] lo_thr_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          up_req_o,
  output logic [AW-1:0] up_idx_o,
  input  logic          up_valid_i,
  input  logic [UW-1:0] up_data_i,
  output logic          done_o,
  output logic          hit_o,
  output logic          err_o,
  output logic [CW-1:0] coarse_o,
  output logic [RW-1:0] refine_o,
  output logic [FW-1:0] frac_o
);
  et_state_e st_q;
  logic [AW-1:0] idx_q, base_q, off;
  logic [KW-1:0] k_q, k_nx;
  logic          buf_clr, buf_full, div_start, div_done;
  logic [NUP-1:0][UW-1:0] pts;
  logic [FW-1:0] div_cnt;
  logic signed [SW-1:0] lo_s, cur_s, nxt_s, den_s, num_s;
  int last_i;

  assign rd_addr_o = idx_q;
  assign done_o    = (st_q == S_DONE);
  assign buf_clr   = (st_q == S_IDLE) && start_i;
  assign off       = idx_q - base_q;
  assign last_i    = (int'(base_q) + SUB - 1 > N - 1) ? N - 1 : int'(base_q) + SUB - 1;

  assign k_nx  = k_q + 1'b1;
  assign lo_s  = $signed({{(SW-DW){1'b0}}, lo_thr_i});
  assign cur_s = SW'($signed(pts[k_q]));
  assign nxt_s = SW'($signed(pts[k_nx]));
  assign den_s = nxt_s - cur_s;
  assign num_s = lo_s - cur_s;
  // defensive: the backward scan already implies den > 0 unless k is last
  assign div_start = (st_q == S_FINE) && (cur_s <= lo_s) &&
                     (k_q != KW'(NUP - 1)) && (den_s > 0);

  et_upbuf #(.NUP(NUP), .UW(UW)) u_upbuf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .valid_i(up_valid_i), .data_i(up_data_i),
    .full_o(buf_full), .pts_o(pts)
  );

  et_serdiv #(.SW(SW), .LIMIT(LIMIT)) u_div (
    .clk_i, .rst_ni, .start_i(div_start), .num_i(num_s), .den_i(den_s),
    .done_o(div_done), .cnt_o(div_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; idx_q <= '0; base_q <= '0; k_q <= '0;
      up_req_o <= 1'b0; up_idx_o <= '0;
      hit_o <= 1'b0; err_o <= 1'b0; coarse_o <= '0; refine_o <= '0; frac_o <= '0;
    end else begin
      up_req_o <= 1'b0;
      unique case (st_q)
        S_IDLE: if (start_i) begin
          idx_q <= '0; hit_o <= 1'b0; err_o <= 1'b0;
          coarse_o <= '0; refine_o <= '0; frac_o <= '0;
          st_q <= S_TRIG;
        end
        S_TRIG: begin
          if (rd_data_i >= trig_lvl_i) begin
            hit_o  <= 1'b1;
            base_q <= (idx_q >= AW'(PRE)) ? idx_q - AW'(PRE) : '0;
            idx_q  <= (idx_q >= AW'(PRE)) ? idx_q - AW'(PRE) : '0;
            st_q   <= S_HIGH;
          end else if (idx_q == AW'(N - 1)) st_q <= S_DONE;
          else idx_q <= idx_q + 1'b1;
        end
        S_HIGH: begin
          if (rd_data_i >= hi_thr_i) st_q <= S_LOW;
          else if (int'(idx_q) == last_i) begin err_o <= 1'b1; st_q <= S_DONE; end
          else idx_q <= idx_q + 1'b1;
        end
        S_LOW: begin
          if (rd_data_i <= lo_thr_i) begin
            coarse_o <= CW'(off) * CW'(TENTHS);
            up_idx_o <= idx_q;
            up_req_o <= 1'b1;
            st_q     <= S_UPW;
          end else if (idx_q == base_q) begin err_o <= 1'b1; st_q <= S_DONE; end
          else idx_q <= idx_q - 1'b1;
        end
        S_UPW: if (buf_full) begin k_q <= KW'(NUP - 1); st_q <= S_FINE; end
        S_FINE: begin
          if (cur_s <= lo_s) begin
            refine_o <= RW'(k_q) * RW'(STEP);
            if (div_start) st_q <= S_DIV;
            else begin err_o <= 1'b1; st_q <= S_DONE; end
          end else if (k_q == '0) begin err_o <= 1'b1; st_q <= S_DONE; end
          else k_q <= k_q - 1'b1;
        end
        S_DIV: if (div_done) begin frac_o <= div_cnt; st_q <= S_DONE; end
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_req_o |=> !up_req_o); // R4
  AST_ERR_NO_FRAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (frac_o == '0)); // R7
  AST_NOHIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (!err_o && coarse_o == '0 && refine_o == '0)); // R1
  AST_COARSE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(coarse_o) <= (SUB - 1) * TENTHS)); // R3
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE && !start_i) |=> $stable(frac_o) && $stable(err_o)); // R9
endmodule

// File: tb/edge_timer_bench.sv
module edge_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64, DW = 12, UW = 16, PRE = 9, SUB = 15, NUP = 8, LIMIT = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DW-1:0] trig_lvl, hi_thr, lo_thr, rd_data;
  logic [5:0] rd_addr, up_idx;
  logic up_req, up_valid = 1'b0, done, hit, err;
  logic [UW-1:0] up_data = '0;
  logic [7:0] coarse;
  logic [3:0] refine, frac;

  logic [DW-1:0] mem [N];
  int upv [NUP];
  int trig, hi, lo, umode;
  int e_hit, e_err, e_coarse, e_refine, e_frac, e_req, e_lidx;
  int checks = 0, fails = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rd_data  = mem[rd_addr];
  assign trig_lvl = DW'(trig);
  assign hi_thr   = DW'(hi);
  assign lo_thr   = DW'(lo);

  edge_timer u_edge_timer (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .trig_lvl_i(trig_lvl), .hi_thr_i(hi_thr), .lo_thr_i(lo_thr),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .up_req_o(up_req), .up_idx_o(up_idx), .up_valid_i(up_valid), .up_data_i(up_data),
    .done_o(done), .hit_o(hit), .err_o(err),
    .coarse_o(coarse), .refine_o(refine), .frac_o(frac)
  );

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic void summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endfunction

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d expected %0d", wd, 0);
      summary();
      $finish;
    end
  end

  task automatic fill(int v);
    for (int i = 0; i < N; i++) mem[i] = DW'(v);
  endtask

  task automatic predict();
    int t = -1, base, last, h = -1, l = -1, k = -1, den, num, c;
    e_hit = 0; e_err = 0; e_coarse = 0; e_refine = 0; e_frac = 0; e_req = 0; e_lidx = 0;
    for (int i = 0; i < N; i++) if (t < 0 && int'(mem[i]) >= trig) t = i;
    if (t < 0) return;
    e_hit = 1;
    base = (t >= PRE) ? t - PRE : 0;
    last = (base + SUB - 1 > N - 1) ? N - 1 : base + SUB - 1;
    for (int j = base; j <= last; j++) if (h < 0 && int'(mem[j]) >= hi) h = j;
    if (h < 0) begin e_err = 1; return; end
    for (int j = h; j >= base; j--) if (l < 0 && int'(mem[j]) <= lo) l = j;
    if (l < 0) begin e_err = 1; return; end
    e_coarse = (l - base) * 10; e_req = 1; e_lidx = l;
    if (umode == 0) begin
      int a = mem[l];
      int b = mem[(l + 1 > N - 1) ? N - 1 : l + 1];
      for (int j = 0; j < NUP; j++) upv[j] = a + ((b - a) * (2 * j - 2)) / 10;
    end
    for (int j = NUP - 1; j >= 0; j--) if (k < 0 && upv[j] <= lo) k = j;
    if (k < 0) begin e_err = 1; return; end
    e_refine = 2 * k;
    if (k == NUP - 1) begin e_err = 1; return; end
    den = upv[k + 1] - upv[k];
    if (den <= 0) begin e_err = 1; return; end
    num = lo - upv[k];
    c = 0;
    while (c < LIMIT && c * den < num * LIMIT) c++;
    e_frac = c;
  endtask

  task automatic run(int poke);
    int cyc = 0, feed = NUP, reqs = 0, got_lidx = -1;
    predict();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && cyc < 2000) begin
      if (up_req) begin reqs++; got_lidx = up_idx; feed = 0; end
      if (feed < NUP) begin up_valid = 1'b1; up_data = UW'(upv[feed]); feed++; end
      else up_valid = 1'b0;
      start = (poke != 0 && cyc == 2);
      @(negedge clk); cyc++;
    end
    up_valid = 1'b0; start = 1'b0;
    chk("R9 done reached", int'(done), 1);
    chk("R1 hit", int'(hit), e_hit);
    chk("R6 err", int'(err), e_err);
    chk("R3 coarse", int'(coarse), e_coarse);
    chk("R5 refine", int'(refine), e_refine);
    chk("R7 frac", int'(frac), e_frac);
    chk("R4 request count", reqs, e_req);
    if (e_req != 0) chk("R4 up_idx", got_lidx, e_lidx);
    @(negedge clk);
    chk("R9 done single cycle", int'(done), 0);
    chk("R9 result held", int'(frac), e_frac);
  endtask

  task automatic load_pulse();
    int vals [17] = '{108, 98, 89, 77, 57, 44, 51, 71, 94, 117, 174, 375, 257, 1287, 1294, 2196, 2423};
    fill(100);
    for (int i = 0; i < 17; i++) mem[41 + i] = DW'(vals[i]);
    for (int i = 58; i < N; i++) mem[i] = DW'(2400);
  endtask

  initial begin
    trig = 300; hi = 231; lo = 111; umode = 0;
    fill(0);
    repeat (3) @(negedge clk);
    chk("R9 reset done", int'(done), 0);
    chk("R1 reset hit", int'(hit), 0);
    chk("R4 reset req", int'(up_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: last upsampled point chosen, trigger at 52, window from 43, crossing at 49
    load_pulse(); umode = 1;
    upv = '{91, 97, 102, 107, 110, 109, 107, 107};
    run(0);
    chk("R3 coarse example", int'(coarse), 60);
    chk("R6 refine example", int'(refine), 14);

    // R7: linear points, expect point 4 and frac 7
    umode = 0; run(0);
    chk("R7 frac example", int'(frac), 7);

    // R10: start pulse mid-run ignored
    run(1);
    chk("R10 frac after poke", int'(frac), 7);

    // R5: no point at or below low threshold
    umode = 1; upv = '{200, 200, 200, 200, 200, 200, 200, 200};
    run(0);
    // R7: point equals threshold gives zero fraction
    upv = '{50, 60, 70, 80, 111, 200, 300, 400};
    run(0);
    // R8: division reaches its cap
    upv = '{0, 0, 0, 0, 0, 0, 0, 112};
    run(0);
    chk("R8 frac capped", int'(frac), 8);

    // R1: no trigger
    umode = 0; fill(100); run(0);
    // R2: early trigger clamps window start to 0
    fill(60); mem[0] = 60; mem[1] = 100; mem[2] = 250; mem[3] = 400; run(0);
    // R3: no sample reaches the high threshold
    hi = 500; fill(60); mem[20] = 400; run(0);
    hi = 231;
    // R3: no sample at or below the low threshold
    lo = 50; fill(100); mem[20] = 400; run(0);
    lo = 111;
    // R2: window cut at buffer end
    fill(60); mem[62] = 80; mem[63] = 400; run(0);

    // sweep of ramp position and slope
    for (int s = 0; s < 3; s++) begin
      int slope = (s == 0) ? 37 : (s == 1) ? 90 : 250;
      for (int p = 0; p < N; p += 2) begin
        for (int i = 0; i < N; i++) begin
          int v = (i < p) ? 60 : 60 + (i - p + 1) * slope;
          mem[i] = DW'((v > 4095) ? 4095 : v);
        end
        run(0);
      end
    end

    summary();
    $finish;
  end
endmodule